// File: doc/BRIEF.md
# Cascadable FIFO slice ring

This block is a first-in first-out buffer built from identical storage slices. Each slice can work on its own as a plain circular FIFO, or sit in a ring with its neighbours so that the ring behaves as one deeper FIFO with no extra latency. All slices see the same write strobe, read strobe and write data. Ownership of writing and ownership of reading are two tokens that travel around the ring. A slice that fills its last location passes the write token onward with a one-cycle active-low pulse on its write-token output. A slice that drains its last location passes the read token onward in the same way on its read-token output.

Each slice chooses its mode during reset from the level on its incoming write-token line. A line held low gives solo mode, and the slice keeps both tokens for good. A line that idles high gives ring mode. In ring mode only the slice whose first-load input is held low starts with the two tokens. Only the slice that accepted a read drives the shared read bus in the next cycle; every other slice forces its contribution to zero, and the wrapper ORs the contributions. The wrapper also forms the composite flags from the per-slice flags. A parameter selects a single solo slice or a ring of NUM_SLICES slices.

Top module: `ring_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it, `empty`=1, `full`=0, `rd_valid`=0, every bit of `slice_empty` is 1 and every bit of `slice_full` is 0.
- R2: Words are read out in the order they were accepted, across every slice boundary and across the wrap from the last slice back to slice 0. A read accepted at a clock edge presents its word on `rd_data` with `rd_valid`=1 in the cycle after that edge.
- R3: A write strobe while `full`=1 is ignored: no word is stored and `full` stays 1 unless a read is accepted.
- R4: A read strobe while `empty`=1 is ignored: `rd_valid` stays 0 in the next cycle.
- R5: After reset, writes go to slice 0 only. Slice k+1 receives its first word on the write that follows the DEPTH-th word stored in slice k, so exactly one slice owns writing at any time.
- R6: Reads drain slice 0 first. Slice k+1 gives up its first word only after slice k has given up its last one, so exactly one slice owns reading at any time.
- R7: `full`=1 exactly when every slice is full (NUM_SLICES*DEPTH words stored), and `empty`=1 exactly when every slice is empty.
- R8: When `rd_valid`=0, `rd_data` is all zeros.
- R9: With NUM_SLICES=1 the slice runs in solo mode. It holds DEPTH words, wraps its pointers around its own storage and reports `full` after DEPTH writes.
- R10: A read and a write in the same cycle both take effect when the FIFO is neither empty nor full. The stored word count stays the same, also when either token changes hands in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode and token ownership are taken while low |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rd_data | output | DATA_W | Read word, zero when no slice drives it |
| rd_valid | output | 1 | High in the cycle that follows an accepted read |
| full | output | 1 | Composite full flag |
| empty | output | 1 | Composite empty flag |
| slice_full | output | NUM_SLICES | Per-slice full flags |
| slice_empty | output | NUM_SLICES | Per-slice empty flags |

## Verification
The assertions assume that reset is held for several cycles. This lets every slice see its neighbour's idle-high token line and settle its mode before the first strobe. They also assume that strobes are only sampled while reset is released. Under these assumptions they require exactly one owner of each token and a quiet bus when no read is returned. The bench holds reset for five cycles and changes strobes and data one time unit after a rising edge, so every sampled value is stable. It deliberately presses strobes against a full and an empty FIFO, so the rules on ignored operations are exercised.

// File: rtl/ring_fifo_pkg.sv
`timescale 1ns/1ps
package ring_fifo_pkg;
    // Operating mode latched by every slice while reset is low.
    typedef enum logic {
        MODE_SOLO = 1'b0,
        MODE_RING = 1'b1
    } ring_mode_e;
endpackage

// File: rtl/slice_ram.sv
`timescale 1ns/1ps
module slice_ram #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/ring_slice.sv
`timescale 1ns/1ps
module ring_slice
    import ring_fifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 512,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              first_load_n,
    input  logic              tok_wr_in_n,
    input  logic              tok_rd_in_n,
    output logic              tok_wr_out_n,
    output logic              tok_rd_out_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              full_o,
    output logic              empty_o,
    output logic              wr_own_o,
    output logic              rd_own_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          wtok;
        logic          rtok;
        ring_mode_e    mode;
        logic          oe;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic full_s, empty_s, ring_s;
    logic wr_go, rd_go, wr_pass, rd_pass;
    logic [DATA_W-1:0] ram_q;

    always_comb begin
        full_s  = (st_q.cnt == CAP);
        empty_s = (st_q.cnt == '0);
        ring_s  = (st_q.mode == MODE_RING);
        wr_go   = wr_en && st_q.wtok && !full_s;
        rd_go   = rd_en && st_q.rtok && !empty_s;
        wr_pass = ring_s && wr_go && (st_q.wptr == LAST);
        rd_pass = ring_s && rd_go && (st_q.rptr == LAST);

        st_d = st_q;
        if (wr_go) st_d.wptr = (st_q.wptr == LAST) ? '0 : st_q.wptr + 1'b1;
        if (rd_go) st_d.rptr = (st_q.rptr == LAST) ? '0 : st_q.rptr + 1'b1;
        st_d.cnt = st_q.cnt + CW'(wr_go) - CW'(rd_go);
        st_d.oe  = rd_go;

        if (ring_s) begin
            if (wr_pass)           st_d.wtok = 1'b0;
            else if (!tok_wr_in_n) st_d.wtok = 1'b1;
            if (rd_pass)           st_d.rtok = 1'b0;
            else if (!tok_rd_in_n) st_d.rtok = 1'b1;
        end

        if (!rst_n) begin
            st_d      = '0;
            st_d.mode = ring_mode_e'(tok_wr_in_n);
            st_d.wtok = !tok_wr_in_n || !first_load_n;
            st_d.rtok = !tok_wr_in_n || !first_load_n;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    slice_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_go),
        .waddr (st_q.wptr),
        .wdata (wr_data),
        .re    (rd_go),
        .raddr (st_q.rptr),
        .rdata (ram_q)
    );

    assign tok_wr_out_n = !wr_pass;
    assign tok_rd_out_n = !rd_pass;
    assign dout         = st_q.oe ? ram_q : '0;
    assign dout_oe      = st_q.oe;
    assign full_o       = full_s;
    assign empty_o      = empty_s;
    assign wr_own_o     = st_q.wtok;
    assign rd_own_o     = st_q.rtok;
endmodule

// File: rtl/ring_fifo.sv
`timescale 1ns/1ps
module ring_fifo #(
    parameter int DATA_W     = 9,
    parameter int DEPTH      = 512,
    parameter int NUM_SLICES = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_en,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_valid,
    output logic                  full,
    output logic                  empty,
    output logic [NUM_SLICES-1:0] slice_full,
    output logic [NUM_SLICES-1:0] slice_empty
);
    logic [NUM_SLICES-1:0] xo_wr_n, xo_rd_n, xi_wr_n, xi_rd_n;
    logic [NUM_SLICES-1:0] oe, wr_own, rd_own;
    logic [DATA_W-1:0]     dout [NUM_SLICES];

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
        if (NUM_SLICES == 1) begin : g_solo
            assign xi_wr_n[i] = 1'b0;
            assign xi_rd_n[i] = 1'b0;
        end else begin : g_ring
            localparam int PREV = (i + NUM_SLICES - 1) % NUM_SLICES;
            assign xi_wr_n[i] = xo_wr_n[PREV];
            assign xi_rd_n[i] = xo_rd_n[PREV];
        end

        ring_slice #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_slice (
            .clk          (clk),
            .rst_n        (rst_n),
            .wr_en        (wr_en),
            .wr_data      (wr_data),
            .rd_en        (rd_en),
            .first_load_n ((i == 0) ? 1'b0 : 1'b1),
            .tok_wr_in_n  (xi_wr_n[i]),
            .tok_rd_in_n  (xi_rd_n[i]),
            .tok_wr_out_n (xo_wr_n[i]),
            .tok_rd_out_n (xo_rd_n[i]),
            .dout         (dout[i]),
            .dout_oe      (oe[i]),
            .full_o       (slice_full[i]),
            .empty_o      (slice_empty[i]),
            .wr_own_o     (wr_own[i]),
            .rd_own_o     (rd_own[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SLICES; i++) rd_data |= dout[i];
    end

    assign rd_valid = |oe;
    assign full     = &slice_full;
    assign empty    = &slice_empty;
endmodule

// File: rtl/ring_fifo_chk.sv
`timescale 1ns/1ps
module ring_fifo_chk #(
    parameter int DATA_W     = 9,
    parameter int NUM_SLICES = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_en,
    input logic [DATA_W-1:0]     rd_data,
    input logic                  rd_valid,
    input logic                  full,
    input logic                  empty,
    input logic [NUM_SLICES-1:0] wr_own,
    input logic [NUM_SLICES-1:0] rd_own
);
    assert_one_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_own) == 1);

    assert_one_reader_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rd_own) == 1);

    assert_quiet_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> !rd_valid);

    assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);

    assert_flags_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

bind ring_fifo ring_fifo_chk #(.DATA_W(DATA_W), .NUM_SLICES(NUM_SLICES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .full     (full),
    .empty    (empty),
    .wr_own   (wr_own),
    .rd_own   (rd_own)
);

// File: tb/ring_fifo_tb.sv
`timescale 1ns/1ps
module ring_fifo_tb;
    localparam int DW  = 9;
    localparam int DEP = 512;
    localparam int NS  = 3;
    localparam int CAP = DEP * NS;
    localparam int SDEP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid, full, empty;
    logic [NS-1:0] slice_full, slice_empty;

    logic          s_wr = 0, s_rd = 0;
    logic [DW-1:0] s_wdata = '0, s_rdata;
    logic          s_valid, s_full, s_empty;
    logic [0:0]    s_sfull, s_sempty;

    ring_fifo #(.DATA_W(DW), .DEPTH(DEP), .NUM_SLICES(NS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty),
        .slice_full(slice_full), .slice_empty(slice_empty));

    ring_fifo #(.DATA_W(DW), .DEPTH(SDEP), .NUM_SLICES(1)) u_solo (
        .clk(clk), .rst_n(rst_n), .wr_en(s_wr), .wr_data(s_wdata), .rd_en(s_rd),
        .rd_data(s_rdata), .rd_valid(s_valid), .full(s_full), .empty(s_empty),
        .slice_full(s_sfull), .slice_empty(s_sempty));

    int total = 0, bad = 0;
    int mcount = 0;
    logic [DW-1:0] sb [$];
    logic exp_valid = 0, next_exp = 0;
    bit   run = 0, done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; the scoreboard predicts acceptance.
    task automatic drive(input logic w, input logic [DW-1:0] d, input logic r);
        bit w_ok, r_ok;
        @(posedge clk);
        exp_valid = next_exp;
        #1;
        w_ok = w && (mcount < CAP);
        r_ok = r && (mcount > 0);
        wr_en = w; wr_data = d; rd_en = r;
        if (w_ok) sb.push_back(d);
        mcount += int'(w_ok) - int'(r_ok);
        next_exp = r_ok;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 37 + 5);
    endfunction

    // Monitor: compares returned words with the scoreboard queue.
    always @(negedge clk) begin
        if (run) begin
            logic [DW-1:0] e;
            if (rd_valid !== exp_valid)
                chk(0, "R2/R4 rd_valid", int'(rd_valid), int'(exp_valid));
            if (rd_valid === 1'b1) begin
                if (sb.size() == 0) chk(0, "R2 unexpected word", int'(rd_data), -1);
                else begin
                    e = sb.pop_front();
                    chk(rd_data === e, "R2 order", int'(rd_data), int'(e));
                end
            end else if (rd_data !== '0) begin
                chk(0, "R8 idle bus", int'(rd_data), 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog R2", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (5) @(posedge clk);
        #1;
        chk(empty === 1 && full === 0 && rd_valid === 0, "R1 flags in reset", int'({full, empty}), 1);
        rst_n = 1'b1;
        @(posedge clk); #1;
        run = 1;
        chk(empty === 1 && full === 0, "R1 composite after reset", int'({full, empty}), 1);
        chk(slice_empty === '1 && slice_full === '0, "R1 slice flags", int'(slice_empty), 7);

        // R4: read on an empty ring
        drive(0, '0, 1);
        drive(0, '0, 0);
        chk(empty === 1, "R4 still empty", int'(empty), 1);

        // R5: first slice fills before the second receives anything
        n = 0;
        repeat (DEP) begin drive(1, pat(n), 0); n++; end
        drive(0, '0, 0);
        chk(slice_full === 3'b001, "R5 slice0 full only", int'(slice_full), 1);
        chk(slice_empty === 3'b110, "R5 slice1 untouched", int'(slice_empty), 6);
        drive(1, pat(n), 0); n++;
        drive(0, '0, 0);
        chk(slice_empty === 3'b100, "R5 token moved to slice1", int'(slice_empty), 4);

        // R7: fill the ring
        while (mcount < CAP) begin drive(1, pat(n), 0); n++; end
        drive(0, '0, 0);
        chk(full === 1 && empty === 0, "R7 full when all slices full", int'(full), 1);
        chk(slice_full === 3'b111, "R7 slice flags all full", int'(slice_full), 7);

        // R3: write while full is dropped
        drive(1, 9'h1AA, 0);
        drive(0, '0, 0);
        chk(full === 1, "R3 full kept", int'(full), 1);

        // R6: reads drain slice 0 first
        repeat (DEP) drive(0, '0, 1);
        drive(0, '0, 0);
        chk(slice_empty === 3'b001, "R6 slice0 drained first", int'(slice_empty), 1);
        chk(slice_full === 3'b110, "R6 others untouched", int'(slice_full), 6);
        chk(full === 0, "R7 full drops", int'(full), 0);

        // R10: concurrent read and write across token hand-offs
        repeat (600) begin drive(1, pat(n), 1); n++; end
        drive(0, '0, 0);
        chk(full === 0 && empty === 0, "R10 level steady", int'({full, empty}), 0);
        chk(mcount == 2 * DEP, "R10 model count", mcount, 2 * DEP);

        // R2/R7: drain everything, then refill past the wrap
        while (mcount > 0) drive(0, '0, 1);
        drive(0, '0, 0);
        drive(0, '0, 0);
        chk(empty === 1 && slice_empty === 3'b111, "R7 empty when all empty", int'(slice_empty), 7);
        drive(0, '0, 1);
        drive(0, '0, 0);
        chk(empty === 1, "R4 empty read ignored", int'(empty), 1);
        repeat (DEP + 3) begin drive(1, pat(n), 0); n++; end
        while (mcount > 0) drive(0, '0, 1);
        drive(0, '0, 0);
        drive(0, '0, 0);
        chk(sb.size() == 0, "R2 scoreboard drained", sb.size(), 0);

        // R9: solo slice
        for (int k = 0; k < SDEP + 1; k++) begin
            @(posedge clk); #1;
            s_wr = 1; s_wdata = DW'(100 + k);
        end
        @(posedge clk); #1; s_wr = 0;
        chk(s_full === 1 && s_sfull === 1'b1, "R9 solo full at depth", int'(s_full), 1);
        for (int k = 0; k < SDEP; k++) begin
            s_rd = 1;
            @(posedge clk); #1; s_rd = 0;
            chk(s_valid === 1 && s_rdata === DW'(100 + k), "R9 solo order", int'(s_rdata), 100 + k);
        end
        chk(s_empty === 1, "R9 solo empty, extra write dropped (R3)", int'(s_empty), 1);
        for (int lap = 0; lap < 3; lap++) begin
            for (int k = 0; k < 5; k++) begin
                @(posedge clk); #1; s_wr = 1; s_wdata = DW'(200 + lap * 5 + k);
            end
            @(posedge clk); #1; s_wr = 0;
            for (int k = 0; k < 5; k++) begin
                s_rd = 1;
                @(posedge clk); #1; s_rd = 0;
                chk(s_rdata === DW'(200 + lap * 5 + k), "R9 solo wrap", int'(s_rdata), 200 + lap * 5 + k);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule